// File: doc/BRIEF.md
# Narrow-to-Wide Write Packer

This block sits between a narrow write port and a FIFO whose storage is only written in whole 36-bit long words. Each write on the narrow port carries either an 18-bit word or a 9-bit byte. The block keeps the earlier slices of a long word in auxiliary registers. The write that carries the last slice completes the long word, and on that same clock edge the block issues a FIFO push with the whole long word.

The long word is made of four 9-bit lanes: lane 3 is bits 35..27, lane 2 is bits 26..18, lane 1 is bits 17..9 and lane 0 is bits 8..0. Two modes decide which lanes each write fills. Both are taken from configuration inputs while reset is held and stay fixed after reset is released. The first mode picks byte or word bus size, which gives four writes or two writes per long word. The second picks the fill order: big-endian fills from lane 3 downward and little-endian fills from lane 0 upward. The FIFO full input stops only the write that would complete a long word.

Top module: `wpk_top`

## Requirements
- R1: While `rst_n` is low and in the cycle after release, `push` is low. The first long word after reset needs a full set of slices: four writes in byte mode, two in word mode.
- R2: In big-endian byte mode (`cfg_big_end`=1, `cfg_byte`=1 at reset), writes 1 to 4 fill lane 3 (bits 35..27), lane 2, lane 1 and lane 0 in that order, each from `wr_data[8:0]`.
- R3: In little-endian byte mode (`cfg_big_end`=0, `cfg_byte`=1), writes 1 to 4 fill lane 0 (bits 8..0), lane 1, lane 2 and lane 3 in that order.
- R4: In big-endian word mode (`cfg_big_end`=1, `cfg_byte`=0), the first write fills bits 35..18 and the second write fills bits 17..0. In each write, `wr_data[17:9]` goes to the higher lane of the pair.
- R5: In little-endian word mode (`cfg_big_end`=0, `cfg_byte`=0), the first write fills bits 17..0 and the second write fills bits 35..18.
- R6: In byte mode, `wr_data[17:9]` has no effect on any long word that is pushed.
- R7: `push` is high only in a cycle where `wr_en` is high and the current slice completes the long word. In that cycle, `push_data` holds the earlier slices together with the current slice. The next write starts a new long word.
- R8: A completing write while `fifo_full`=1 gives no push, and the fill position does not advance. Later, the same slice position accepts a new write that pushes. A non-completing write is still accepted while full.
- R9: Changes on `cfg_big_end` and `cfg_byte` after reset release have no effect on packing.
- R10: Reset discards a partly built long word, and packing restarts at the first slice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low; modes are sampled while low |
| cfg_big_end | input | 1 | Fill order selection: 1 = from lane 3 down, 0 = from lane 0 up |
| cfg_byte | input | 1 | Bus size selection: 1 = 9-bit bytes, 0 = 18-bit words |
| wr_en | input | 1 | Narrow write strobe |
| wr_data | input | 18 | Narrow write data |
| fifo_full | input | 1 | FIFO full; blocks a completing write |
| push | output | 1 | FIFO write strobe, same cycle as the completing slice |
| push_data | output | 36 | Long word to be written into the FIFO |

## Verification
All four mode combinations are tried with distinct lane values, so a mistake in lane order or pairing shows up at once in `push_data`. Byte-mode writes carry garbage on the upper nine lines, which would show if they leaked into the packed word. A completing write is blocked by full and then retried with new data: this separates "position held" from "position advanced" and from "blocked data kept". A mode flip after reset and a reset in the middle of a word show whether the latched modes and the slice count can be disturbed.

// File: rtl/wpk_pkg.sv
package wpk_pkg;
    typedef struct packed {
        logic big_end;
        logic narrow;
    } wpk_mode_t;
endpackage

// File: rtl/wpk_mode_latch.sv
module wpk_mode_latch
    import wpk_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cfg_big_end,
    input  logic      cfg_byte,
    output wpk_mode_t mode_q
);
    wpk_mode_t mode_d;

    always_comb begin
        mode_d = mode_q;
        if (!rst_n) begin
            mode_d.big_end = cfg_big_end;
            mode_d.narrow  = cfg_byte;
        end
    end

    always_ff @(posedge clk) begin
        mode_q <= mode_d;
    end

    AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(mode_q)) else $error("mode changed after reset"); // R9
endmodule

// File: rtl/wpk_slice_ctrl.sv
module wpk_slice_ctrl
    import wpk_pkg::*;
#(
    parameter int LANES = 4,
    localparam int IDX_W = $clog2(LANES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  wpk_mode_t        mode,
    input  logic             wr_en,
    input  logic             fifo_full,
    output logic [IDX_W-1:0] idx_q,
    output logic             take,
    output logic             push
);
    typedef struct packed {
        logic [IDX_W-1:0] idx;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic [IDX_W-1:0] last_idx;
    logic             is_last;

    always_comb begin
        last_idx = mode.narrow ? IDX_W'(LANES - 1) : IDX_W'(LANES / 2 - 1);
        is_last  = (st_q.idx == last_idx);
        push     = wr_en && is_last && !fifo_full;
        take     = wr_en && (!is_last || !fifo_full);
        st_d     = st_q;
        if (push)
            st_d.idx = '0;
        else if (take)
            st_d.idx = st_q.idx + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign idx_q = st_q.idx;

    AST_IDX_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> (idx_q == '0)) else $error("index not restarted"); // R7
    AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(idx_q) < (mode.narrow ? LANES : LANES / 2))) else $error("index range"); // R1
    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && fifo_full && is_last) |=> $stable(idx_q)) else $error("full advanced"); // R8
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(idx_q)) else $error("idle advanced"); // R7
endmodule

// File: rtl/wpk_lane_map.sv
module wpk_lane_map
    import wpk_pkg::*;
#(
    parameter int LANE_W = 9,
    parameter int LANES  = 4,
    localparam int IDX_W = $clog2(LANES),
    localparam int WIDE_W = LANE_W * LANES
) (
    input  wpk_mode_t          mode,
    input  logic [IDX_W-1:0]   idx,
    input  logic [2*LANE_W-1:0] wr_data,
    output logic [LANES-1:0]   lane_sel,
    output logic [WIDE_W-1:0]  slice_word
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        localparam int PAIR = l / 2;
        logic sel_byte, sel_word;
        always_comb begin
            sel_byte = mode.big_end ? (int'(idx) == LANES - 1 - l) : (int'(idx) == l);
            sel_word = mode.big_end ? (int'(idx) == LANES / 2 - 1 - PAIR) : (int'(idx) == PAIR);
            lane_sel[l] = mode.narrow ? sel_byte : sel_word;
            if (mode.narrow || (l % 2 == 0))
                slice_word[l*LANE_W +: LANE_W] = wr_data[LANE_W-1:0];
            else
                slice_word[l*LANE_W +: LANE_W] = wr_data[2*LANE_W-1:LANE_W];
        end
    end
endmodule

// File: rtl/wpk_aux_store.sv
module wpk_aux_store #(
    parameter int LANE_W = 9,
    parameter int LANES  = 4,
    localparam int WIDE_W = LANE_W * LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              narrow,
    input  logic              take,
    input  logic              push,
    input  logic [LANES-1:0]  lane_sel,
    input  logic [WIDE_W-1:0] slice_word,
    output logic [WIDE_W-1:0] push_data
);
    typedef struct packed {
        logic [WIDE_W-1:0] aux;
    } aux_t;

    aux_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int l = 0; l < LANES; l++) begin
            if (lane_sel[l]) begin
                push_data[l*LANE_W +: LANE_W] = slice_word[l*LANE_W +: LANE_W];
                if (take && !push)
                    st_d.aux[l*LANE_W +: LANE_W] = slice_word[l*LANE_W +: LANE_W];
            end else begin
                push_data[l*LANE_W +: LANE_W] = st_q.aux[l*LANE_W +: LANE_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_LANE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> ($countones(lane_sel) == (narrow ? 1 : 2))) else $error("lane count"); // R4
    AST_NO_AUX_ON_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> $stable(st_q.aux)) else $error("aux written on push"); // R7
endmodule

// File: rtl/wpk_top.sv
module wpk_top
    import wpk_pkg::*;
#(
    parameter int LANE_W = 9,
    parameter int LANES  = 4,
    localparam int WIDE_W = LANE_W * LANES,
    localparam int IDX_W  = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_big_end,
    input  logic              cfg_byte,
    input  logic              wr_en,
    input  logic [2*LANE_W-1:0] wr_data,
    input  logic              fifo_full,
    output logic              push,
    output logic [WIDE_W-1:0] push_data
);
    wpk_mode_t        mode;
    logic [IDX_W-1:0] idx;
    logic             take;
    logic [LANES-1:0] lane_sel;
    logic [WIDE_W-1:0] slice_word;

    wpk_mode_latch u_mode (
        .clk(clk), .rst_n(rst_n), .cfg_big_end(cfg_big_end),
        .cfg_byte(cfg_byte), .mode_q(mode)
    );

    wpk_slice_ctrl #(.LANES(LANES)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .mode(mode), .wr_en(wr_en),
        .fifo_full(fifo_full), .idx_q(idx), .take(take), .push(push)
    );

    wpk_lane_map #(.LANE_W(LANE_W), .LANES(LANES)) u_map (
        .mode(mode), .idx(idx), .wr_data(wr_data),
        .lane_sel(lane_sel), .slice_word(slice_word)
    );

    wpk_aux_store #(.LANE_W(LANE_W), .LANES(LANES)) u_aux (
        .clk(clk), .rst_n(rst_n), .narrow(mode.narrow), .take(take),
        .push(push), .lane_sel(lane_sel), .slice_word(slice_word),
        .push_data(push_data)
    );

    AST_PUSH_NOT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (wr_en && !fifo_full)) else $error("push while full"); // R8
    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(!rst_n) |-> !push) else $error("push after reset"); // R1
endmodule

// File: tb/wpk_top_tb.sv
module wpk_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_big_end = 1'b1;
    logic        cfg_byte = 1'b1;
    logic        wr_en = 1'b0;
    logic [17:0] wr_data = '0;
    logic        fifo_full = 1'b0;
    logic        push;
    logic [35:0] push_data;
    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    wpk_top u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_big_end(cfg_big_end), .cfg_byte(cfg_byte),
        .wr_en(wr_en), .wr_data(wr_data), .fifo_full(fifo_full),
        .push(push), .push_data(push_data)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input bit be, input bit byt);
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0; fifo_full = 1'b0;
        cfg_big_end = be; cfg_byte = byt;
        repeat (2) @(posedge clk);
        #2 chk(push == 1'b0, "R1 push low in reset", 64'(push), 0);
        @(negedge clk);
        rst_n = 1'b1;
        #2 chk(push == 1'b0, "R1 push low after release", 64'(push), 0);
    endtask

    task automatic wr(input logic [17:0] d, input bit full, input bit exp_push,
                      input logic [35:0] exp_word, input string tag);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d; fifo_full = full;
        #2;
        chk(push == exp_push, {tag, " push"}, 64'(push), 64'(exp_push));
        if (exp_push)
            chk(push_data == exp_word, {tag, " data"}, 64'(push_data), 64'(exp_word));
        @(posedge clk);
        #1 wr_en = 1'b0; fifo_full = 1'b0;
    endtask

    task automatic t_be_byte;
        logic [8:0] b [4] = '{9'h1A1, 9'h0B2, 9'h1C3, 9'h0D4};
        do_reset(1'b1, 1'b1);
        for (int i = 0; i < 4; i++)
            wr({9'h1FF - 9'(i), b[i]}, 1'b0, i == 3, {b[0], b[1], b[2], b[3]}, "R2 R6 be byte");
        for (int i = 0; i < 4; i++)
            wr({9'h155, b[3-i]}, 1'b0, i == 3, {b[3], b[2], b[1], b[0]}, "R7 R1 second word");
    endtask

    task automatic t_le_byte;
        logic [8:0] b [4] = '{9'h011, 9'h122, 9'h033, 9'h144};
        do_reset(1'b0, 1'b1);
        for (int i = 0; i < 4; i++)
            wr({9'h0AA + 9'(i), b[i]}, 1'b0, i == 3, {b[3], b[2], b[1], b[0]}, "R3 R6 le byte");
    endtask

    task automatic t_be_word;
        do_reset(1'b1, 1'b0);
        wr(18'h2_1357, 1'b0, 1'b0, '0, "R4 be word first");
        wr(18'h1_9BDF, 1'b0, 1'b1, {18'h2_1357, 18'h1_9BDF}, "R4 be word second");
    endtask

    task automatic t_le_word;
        do_reset(1'b0, 1'b0);
        wr(18'h0_4321, 1'b0, 1'b0, '0, "R5 le word first");
        wr(18'h3_8765, 1'b0, 1'b1, {18'h3_8765, 18'h0_4321}, "R5 le word second");
    endtask

    task automatic t_full;
        do_reset(1'b1, 1'b0);
        wr(18'h1_1111, 1'b1, 1'b0, '0, "R8 non-final under full");
        wr(18'h2_2222, 1'b1, 1'b0, '0, "R8 final blocked");
        wr(18'h0_3333, 1'b0, 1'b1, {18'h1_1111, 18'h0_3333}, "R8 retry pushes");
    endtask

    task automatic t_mode_latch;
        logic [8:0] b [4] = '{9'h101, 9'h002, 9'h103, 9'h004};
        do_reset(1'b0, 1'b1);
        @(negedge clk);
        cfg_big_end = 1'b1; cfg_byte = 1'b0;
        for (int i = 0; i < 4; i++)
            wr({9'h0F0, b[i]}, 1'b0, i == 3, {b[3], b[2], b[1], b[0]}, "R9 mode latched");
    endtask

    task automatic t_reset_mid;
        logic [8:0] b [4] = '{9'h0E1, 9'h1E2, 9'h0E3, 9'h1E4};
        do_reset(1'b1, 1'b1);
        wr(18'h0_0077, 1'b0, 1'b0, '0, "R10 partial 1");
        wr(18'h0_0088, 1'b0, 1'b0, '0, "R10 partial 2");
        do_reset(1'b1, 1'b1);
        for (int i = 0; i < 4; i++)
            wr({9'h000, b[i]}, 1'b0, i == 3, {b[0], b[1], b[2], b[3]}, "R10 restart");
    endtask

    initial begin
        #(20 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_be_byte();
        t_le_byte();
        t_be_word();
        t_le_word();
        t_full();
        t_mode_latch();
        t_reset_mid();
        repeat (2) @(posedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule